// File: doc/BRIEF.md
# Way-Predicted Four-Way Cache Lookup

This block is the read-lookup engine of a four-way set-associative cache. The mode in force when a request is taken sets how the tag and data arrays are read. Parallel mode reads every tag and every data way together. Phased mode compares all tags first and then reads only the data way that matched. Predicted mode reads a single guessed way first and probes the other three only when the guess is wrong. Each request returns a one-cycle done pulse, a hit flag and the selected data word.

A fill port writes a tag and a data line into the victim way of a set. Each set chooses its victim in round-robin order. Two counters add up how many tag-array reads and data-array reads the lookups have made, so the energy cost of the three modes can be compared on the same workload. A dedicated input clears both counters.

Top module: `wp_cache_lookup`

## Requirements
- R1: An address is split from the top down into a tag of ADDR_W-IDX_W-OFF_W bits, a set index of IDX_W bits and an OFF_W-bit byte offset that the lookup ignores. A hit requires a valid line in the indexed set whose stored tag equals the request tag. rsp_hit is only ever high together with rsp_done.
- R2: Parallel mode (mode 0) raises rsp_done one cycle after acceptance. It adds 4 to tag_reads and 4 to data_reads.
- R3: Phased mode (mode 1) returns a hit two cycles after acceptance and a miss one cycle after acceptance. It adds 4 tag reads, plus 1 data read on a hit and none on a miss.
- R4: In predicted mode (mode 2), when the predicted way holds the line, the hit is returned one cycle after acceptance with 1 tag read and 1 data read.
- R5: In predicted mode, when the predicted way does not hold the line, the result comes two cycles after acceptance. The data comes from whichever other way matches, or a miss is reported, and 4 tag reads and 4 data reads are counted in total.
- R6: Each set predicts the way that most recently hit in that set, or the way most recently filled in it, whichever happened later. A miss leaves the prediction unchanged.
- R7: A fill writes into a per-set victim way that advances 0,1,2,3,0 with each fill to that set. While fill_valid is high, req_ready is low, so a fill always wins over a request in the same cycle.
- R8: req_ready is low from acceptance until the request's done pulse. Every accepted request produces exactly one single-cycle done pulse.
- R9: tag_reads and data_reads are CNT_W-bit counters (32 by default) that stop at their all-ones value. ctr_clear zeroes both on the next clock edge.
- R10: Reset clears every valid bit, both counters and rsp_done, and leaves req_ready and fill_ready high.
- R11: Mode 3 behaves as parallel mode. The mode is sampled only in the cycle a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Access mode for the request being accepted |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | ADDR_W | Lookup byte address |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be written this cycle |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_data | input | DATA_W | Line data to write |
| ctr_clear | input | 1 | Synchronous clear of both read counters |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Lookup hit, valid with rsp_done |
| rsp_data | output | DATA_W | Data of the hitting way, valid with a hit |
| tag_reads | output | CNT_W | Tag-array reads made so far |
| data_reads | output | CNT_W | Data-array reads made so far |

## Verification
A result falls due one cycle after acceptance for parallel lookups, phased misses and correct guesses. It falls due two cycles after acceptance for phased hits and wrong guesses. The counters settle on the same edge that raises done. The bench drives on falling edges and counts falling edges from the accepting rising edge until it sees done, then compares that count with the expected latency of each vector. It reads the hit flag, the data and both counters in the same falling-edge sample. Each vector starts from cleared counters, so the counter values are the exact cost of a single lookup.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int NWAYS = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [NWAYS-1:0] wmask_t;

    typedef enum logic [1:0] {
        MODE_PAR   = 2'd0,
        MODE_PHASE = 2'd1,
        MODE_PRED  = 2'd2,
        MODE_PAR_B = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FULL,
        ST_TAGS,
        ST_DATA,
        ST_PROBE,
        ST_REST
    } state_e;

    // array reads made in one cycle
    typedef struct packed {
        logic [2:0] tag_rd;
        logic [2:0] data_rd;
    } cost_t;

    // lowest numbered way whose bit is set
    function automatic way_t low_way(wmask_t m);
        way_t r;
        r = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (m[i]) r = way_t'(i);
        end
        return r;
    endfunction

    function automatic wmask_t way_bit(way_t w);
        return wmask_t'(1) << w;
    endfunction
endpackage

// File: rtl/wpc_arrays.sv
module wpc_arrays
    import wpc_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [IDX_W-1:0]                  rd_set,
    input  logic [TAG_W-1:0]                  rd_tag,
    output wmask_t                            hit_mask,
    output logic [NWAYS-1:0][DATA_W-1:0]      rd_data,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_set,
    input  way_t                              wr_way,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [DATA_W-1:0]                 wr_data
);
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic              valid_q [SETS];
        logic [TAG_W-1:0]  tag_q   [SETS];
        logic [DATA_W-1:0] line_q  [SETS];
        logic              wr_here;

        assign wr_here = wr_en && (wr_way == way_t'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= 1'b0;
            end else if (wr_here) begin
                valid_q[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_q[wr_set]  <= wr_tag;
                line_q[wr_set] <= wr_data;
            end
        end

        assign hit_mask[w] = valid_q[rd_set] && (tag_q[rd_set] == rd_tag);
        assign rd_data[w]  = line_q[rd_set];
    end
endmodule

// File: rtl/wpc_way_ctl.sv
module wpc_way_ctl
    import wpc_pkg::*;
#(
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_set,
    output way_t             pred_way,
    input  logic             upd_en,
    input  way_t             upd_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    output way_t             victim_way
);
    way_t pred_q [SETS];
    way_t vict_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                pred_q[s] <= '0;
                vict_q[s] <= '0;
            end
        end else if (fill_en) begin
            vict_q[fill_set] <= vict_q[fill_set] + way_t'(1);
            pred_q[fill_set] <= vict_q[fill_set];
        end else if (upd_en) begin
            pred_q[look_set] <= upd_way;
        end
    end

    assign pred_way   = pred_q[look_set];
    assign victim_way = vict_q[fill_set];
endmodule

// File: rtl/wpc_energy_ctr.sv
module wpc_energy_ctr
    import wpc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  cost_t            cost,
    output logic [CNT_W-1:0] tag_cnt,
    output logic [CNT_W-1:0] data_cnt
);
    function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] a, logic [2:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + (CNT_W+1)'(b);
        return s[CNT_W] ? '1 : s[CNT_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tag_cnt  <= '0;
            data_cnt <= '0;
        end else begin
            tag_cnt  <= sat_add(tag_cnt, cost.tag_rd);
            data_cnt <= sat_add(data_cnt, cost.data_rd);
        end
    end
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
    import wpc_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int CNT_W  = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              ctr_clear,
    output logic              rsp_done,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  tag_reads,
    output logic [CNT_W-1:0]  data_reads
);
    state_e                         st_q, st_d;
    logic [IDX_W-1:0]               set_q;
    logic [TAG_W-1:0]               tag_q;
    way_t                           sel_q;
    wmask_t                         hit_mask, rest_mask;
    logic [NWAYS-1:0][DATA_W-1:0]   way_data;
    way_t                           pred_way, victim_way, way_d;
    logic                           done_d, hit_d, upd_en;
    logic                           req_fire, fill_fire;
    cost_t                          cost;
    logic [IDX_W-1:0]               fill_set;
    logic                           unused_offsets;

    assign fill_ready = (st_q == ST_IDLE);
    assign req_ready  = (st_q == ST_IDLE) && !fill_valid;
    assign req_fire   = req_valid && req_ready;
    assign fill_fire  = fill_valid && fill_ready;
    assign fill_set   = fill_addr[OFF_W +: IDX_W];
    assign unused_offsets = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    wpc_arrays #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_arrays (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (set_q),
        .rd_tag   (tag_q),
        .hit_mask (hit_mask),
        .rd_data  (way_data),
        .wr_en    (fill_fire),
        .wr_set   (fill_set),
        .wr_way   (victim_way),
        .wr_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .wr_data  (fill_data)
    );

    wpc_way_ctl #(.SETS(SETS)) i_way_ctl (
        .clk        (clk),
        .rst        (rst),
        .look_set   (set_q),
        .pred_way   (pred_way),
        .upd_en     (upd_en),
        .upd_way    (way_d),
        .fill_en    (fill_fire),
        .fill_set   (fill_set),
        .victim_way (victim_way)
    );

    wpc_energy_ctr #(.CNT_W(CNT_W)) i_energy (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctr_clear),
        .cost     (cost),
        .tag_cnt  (tag_reads),
        .data_cnt (data_reads)
    );

    // ways left after a failed guess
    assign rest_mask = hit_mask & ~way_bit(pred_way);

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        hit_d  = 1'b0;
        way_d  = '0;
        cost   = '0;
        case (st_q)
            ST_IDLE: begin
                if (req_fire) begin
                    case (mode_e'(mode))
                        MODE_PHASE: st_d = ST_TAGS;
                        MODE_PRED:  st_d = ST_PROBE;
                        default:    st_d = ST_FULL;
                    endcase
                end
            end
            ST_FULL: begin
                cost   = '{tag_rd: 3'd4, data_rd: 3'd4};
                done_d = 1'b1;
                hit_d  = |hit_mask;
                way_d  = low_way(hit_mask);
                st_d   = ST_IDLE;
            end
            ST_TAGS: begin
                cost = '{tag_rd: 3'd4, data_rd: 3'd0};
                if (|hit_mask) begin
                    st_d = ST_DATA;
                end else begin
                    done_d = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            ST_DATA: begin
                cost   = '{tag_rd: 3'd0, data_rd: 3'd1};
                done_d = 1'b1;
                hit_d  = 1'b1;
                way_d  = sel_q;
                st_d   = ST_IDLE;
            end
            ST_PROBE: begin
                cost  = '{tag_rd: 3'd1, data_rd: 3'd1};
                way_d = pred_way;
                if (hit_mask[pred_way]) begin
                    done_d = 1'b1;
                    hit_d  = 1'b1;
                    st_d   = ST_IDLE;
                end else begin
                    st_d = ST_REST;
                end
            end
            ST_REST: begin
                cost   = '{tag_rd: 3'd3, data_rd: 3'd3};
                done_d = 1'b1;
                hit_d  = |rest_mask;
                way_d  = low_way(rest_mask);
                st_d   = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign upd_en = done_d && hit_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            rsp_done <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_data <= '0;
        end else begin
            st_q     <= st_d;
            rsp_done <= done_d;
            rsp_hit  <= upd_en;
            rsp_data <= upd_en ? way_data[way_d] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (req_fire) begin
            set_q <= req_addr[OFF_W +: IDX_W];
            tag_q <= req_addr[ADDR_W-1 -: TAG_W];
        end
        if (st_q == ST_TAGS) sel_q <= low_way(hit_mask);
    end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             fill_valid,
    input logic             ctr_clear,
    input logic             rsp_done,
    input logic             rsp_hit,
    input logic [CNT_W-1:0] tag_reads,
    input logic [CNT_W-1:0] data_reads
);
    logic inflight;

    always_ff @(posedge clk) begin
        if (rst) inflight <= 1'b0;
        else if (req_valid && req_ready) inflight <= 1'b1;
        else if (rsp_done) inflight <= 1'b0;
    end

    p_hit_with_done_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_done);

    p_fill_wins_r7: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !req_ready);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_done_owned_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> inflight);

    p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (rst)
        ctr_clear |=> (tag_reads == '0 && data_reads == '0));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        !ctr_clear |=> (tag_reads >= $past(tag_reads) && data_reads >= $past(data_reads)));
endmodule

bind wp_cache_lookup wpc_checker #(.CNT_W(CNT_W)) i_wpc_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .fill_valid (fill_valid),
    .ctr_clear  (ctr_clear),
    .rsp_done   (rsp_done),
    .rsp_hit    (rsp_hit),
    .tag_reads  (tag_reads),
    .data_reads (data_reads)
);

// File: tb/test_wp_cache_lookup.sv
`timescale 1ns/1ps
module test_wp_cache_lookup;
    localparam int CW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        fill_valid = 1'b0;
    logic        fill_ready;
    logic [15:0] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        ctr_clear = 1'b0;
    logic        rsp_done, rsp_hit;
    logic [31:0] rsp_data;
    logic [CW-1:0] tag_reads, data_reads;

    int errs = 0;
    int checks = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    wp_cache_lookup #(.SETS(16), .DATA_W(32), .ADDR_W(16), .OFF_W(2), .CNT_W(CW)) i_wp_cache_lookup (
        .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .fill_valid(fill_valid), .fill_ready(fill_ready),
        .fill_addr(fill_addr), .fill_data(fill_data), .ctr_clear(ctr_clear),
        .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .tag_reads(tag_reads), .data_reads(data_reads)
    );

    // fields: mode[60:59] tag[58:49] set[48:45] off[44:43] hit[42] data[41:10] lat[9:8] tags[7:4] datas[3:0]
    localparam logic [60:0] VEC [12] = '{
        {2'd0, 10'h022, 4'd1, 2'd1, 1'b1, 32'hA0000022, 2'd1, 4'd4, 4'd4}, // R2 parallel hit, R1 offset ignored
        {2'd1, 10'h044, 4'd1, 2'd2, 1'b1, 32'hA0000044, 2'd2, 4'd4, 4'd1}, // R3 phased hit
        {2'd1, 10'h055, 4'd1, 2'd0, 1'b0, 32'h0,        2'd1, 4'd4, 4'd0}, // R3 phased miss
        {2'd0, 10'h055, 4'd1, 2'd3, 1'b0, 32'h0,        2'd1, 4'd4, 4'd4}, // R1 tag mismatch
        {2'd2, 10'h044, 4'd1, 2'd0, 1'b1, 32'hA0000044, 2'd1, 4'd1, 4'd1}, // R4 guess way 3 right, R6
        {2'd2, 10'h011, 4'd1, 2'd0, 1'b1, 32'hA0000011, 2'd2, 4'd4, 4'd4}, // R5 wrong guess, hit way 0
        {2'd2, 10'h011, 4'd1, 2'd1, 1'b1, 32'hA0000011, 2'd1, 4'd1, 4'd1}, // R6 guess follows last hit
        {2'd2, 10'h066, 4'd1, 2'd0, 1'b0, 32'h0,        2'd2, 4'd4, 4'd4}, // R5 predicted miss
        {2'd2, 10'h011, 4'd2, 2'd0, 1'b0, 32'h0,        2'd2, 4'd4, 4'd4}, // R1 empty set misses
        {2'd2, 10'h033, 4'd1, 2'd0, 1'b1, 32'hA0000033, 2'd2, 4'd4, 4'd4}, // R6 miss kept guess 0, R5
        {2'd2, 10'h033, 4'd1, 2'd2, 1'b1, 32'hA0000033, 2'd1, 4'd1, 4'd1}, // R4 guess way 2 now
        {2'd3, 10'h022, 4'd1, 2'd0, 1'b1, 32'hA0000022, 2'd1, 4'd4, 4'd4}  // R11 mode 3 as parallel
    };

    function automatic logic [15:0] mk(logic [9:0] t, logic [3:0] s, logic [1:0] o);
        return {t, s, o};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill(logic [9:0] t, logic [3:0] s);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = mk(t, s, 2'd0);
        fill_data  = 32'hA0000000 | 32'(t);
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic clear_ctr();
        @(negedge clk);
        ctr_clear = 1'b1;
        @(posedge clk);
        #1 ctr_clear = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] m, input logic [15:0] a,
                          output logic h, output logic [31:0] d, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        mode = m;
        req_addr = a;
        req_valid = 1'b1;
        @(posedge clk);
        lat = 0;
        h = 1'b0;
        d = '0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (rsp_done) begin
                h = rsp_hit;
                d = rsp_data;
                break;
            end
            lat++;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!ended) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic h;
        logic [31:0] d;
        int lat;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R10", "ready after reset", {62'd0, req_ready, fill_ready}, 64'd3);
        chk("R10", "done after reset", 64'(rsp_done), 64'd0);
        chk("R10", "counters after reset", {tag_reads, data_reads}, 64'd0);
        lookup(2'd0, mk(10'h022, 4'd1, 2'd0), h, d, lat);
        chk("R10", "no line valid after reset", 64'(h), 64'd0);

        fill(10'h011, 4'd1);
        fill(10'h022, 4'd1);
        fill(10'h033, 4'd1);
        fill(10'h044, 4'd1);

        for (int k = 0; k < 12; k++) begin
            logic [60:0] v;
            v = VEC[k];
            clear_ctr();
            lookup(v[60:59], mk(v[58:49], v[48:45], v[44:43]), h, d, lat);
            chk($sformatf("vec%0d", k), "hit", 64'(h), 64'(v[42]));
            if (v[42]) chk($sformatf("vec%0d", k), "data", 64'(d), 64'(v[41:10]));
            chk($sformatf("vec%0d", k), "latency", 64'(lat), 64'(v[9:8]));
            chk($sformatf("vec%0d", k), "tag reads", 64'(tag_reads), 64'(v[7:4]));
            chk($sformatf("vec%0d", k), "data reads", 64'(data_reads), 64'(v[3:0]));
        end

        // R7: fill and request together, fill wins, victim wraps to way 0; R6: guess moves to filled way
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = mk(10'h077, 4'd1, 2'd0);
        fill_data  = 32'hA0000077;
        mode = 2'd2;
        req_addr = mk(10'h077, 4'd1, 2'd0);
        req_valid = 1'b1;
        #1 chk("R7", "req_ready during fill", 64'(req_ready), 64'd0);
        @(posedge clk);
        #1 fill_valid = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R7", "no response to blocked request", 64'(rsp_done), 64'd0);
        clear_ctr();
        lookup(2'd2, mk(10'h077, 4'd1, 2'd0), h, d, lat);
        chk("R6", "guess at filled way latency", 64'(lat), 64'd1);
        chk("R7", "filled line data", 64'(d), 64'hA0000077);
        lookup(2'd0, mk(10'h011, 4'd1, 2'd0), h, d, lat);
        chk("R7", "victim way 0 replaced", 64'(h), 64'd0);
        lookup(2'd0, mk(10'h022, 4'd1, 2'd0), h, d, lat);
        chk("R7", "way 1 kept", 64'(h), 64'd1);

        // R9 saturation and clear
        clear_ctr();
        for (int k = 0; k < 16; k++) lookup(2'd0, mk(10'h022, 4'd1, 2'd0), h, d, lat);
        chk("R9", "tag reads saturate", 64'(tag_reads), 64'd63);
        chk("R9", "data reads saturate", 64'(data_reads), 64'd63);
        clear_ctr();
        @(negedge clk);
        chk("R9", "clear", {tag_reads, data_reads}, 64'd0);

        // R10 reset drops valid lines
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        lookup(2'd0, mk(10'h022, 4'd1, 2'd0), h, d, lat);
        chk("R10", "line invalid after reset", 64'(h), 64'd0);

        ended = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule